// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the processor-side controller that takes a maskable interrupt from request to handler entry. It starts only when the request line is high and the interrupt-enable flag is set. It then runs a locked pair of acknowledge cycles on the bus and keeps the vector type returned in the second one. After that it saves the context on the stack through a simple write port.

The save sequence has a fixed order. The status word is pushed first. Next, an updated flag word with the trap and interrupt-enable bits cleared is handed back to the flag register. The code segment is pushed after that, and the instruction pointer last.

When the last push has completed, a one-clock completion pulse carries the captured vector type and the lowered stack pointer to the fetch logic. The sequencer then goes back to waiting. Vector table lookup and instruction fetch belong to the logic that consumes the completion pulse.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `ack_strobe`, `bus_lock`, `mem_wr_en`, `flags_wr_en` and `done` are all low.
- R2: While `flags_in` bit 9 (interrupt enable) is 0, a high `irq_req` has no effect: no strobe, no write, no flag update and no done.
- R3: An accepted request produces exactly two `ack_strobe` pulses. Each pulse is `ACK_LEN` clocks wide, and the two are separated by exactly one low clock.
- R4: `bus_lock` is high whenever `ack_strobe` is high and during the clock between the two pulses. It is high for exactly 2*`ACK_LEN`+1 clocks per sequence.
- R5: The vector type is the value on `ack_data` in the last clock of the second strobe pulse. Data presented during the first pulse is ignored.
- R6: The first stack write stores the entry value of `flags_in` at address SP-2, where SP is `sp_in` when the request is accepted.
- R7: After the first write completes and before the second write begins, `flags_wr_en` pulses exactly once. It carries the saved flags with bit 8 (trap) and bit 9 (interrupt enable) cleared and all other bits unchanged.
- R8: The second write stores `cs_in` at SP-4 and the third stores `ip_in` at SP-6. Addresses wrap modulo 2^16.
- R9: A write is complete only at a clock where both `mem_wr_en` and `mem_ready` are high. Until then, `mem_addr` and `mem_wdata` are held stable.
- R10: One clock after the third write completes, `done` is high for exactly one clock. It carries the vector type on `done_vector` and SP-6 on `done_sp`. A later request is accepted again once interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Maskable interrupt request, level |
| flags_in | input | 16 | Current flag word |
| cs_in | input | 16 | Current code segment |
| ip_in | input | 16 | Current instruction pointer |
| sp_in | input | 16 | Current stack pointer |
| ack_strobe | output | 1 | Acknowledge cycle strobe |
| bus_lock | output | 1 | Bus lock across both acknowledge cycles |
| ack_data | input | 8 | Vector type returned during acknowledge |
| mem_wr_en | output | 1 | Stack write request |
| mem_addr | output | 16 | Stack write address |
| mem_wdata | output | 16 | Stack write data |
| mem_ready | input | 1 | Write accepted in this clock |
| flags_wr_en | output | 1 | Flag register update strobe |
| flags_wr_data | output | 16 | Updated flag word |
| done | output | 1 | Entry sequence complete |
| done_vector | output | 8 | Captured vector type |
| done_sp | output | 16 | Stack pointer after the three pushes |

## Verification
Several properties are checked on every clock: the lock covers any strobe, a waiting write holds its address and data, a strobe never overlaps a stack write, the flag update always has both bits cleared, no acknowledge starts while interrupts are masked, and done never lasts two clocks. The order of the pushes and their addresses and data are shown only by the bench's scenarios. The same holds for the choice of the second cycle's vector, the pulse widths and the gap, and the final stack pointer, including a stack that wraps past zero and writes stalled by a slow ready.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  parameter int TF_POS = 8;
  parameter int IF_POS = 9;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ACK,
    S_PUSH_FL,
    S_CLR_FL,
    S_PUSH_CS,
    S_PUSH_IP,
    S_FIN
  } seq_state_e;

  typedef enum logic [1:0] {
    A_IDLE,
    A_ONE,
    A_GAP,
    A_TWO
  } ack_state_e;
endpackage

// File: rtl/irq_ack_unit.sv
module irq_ack_unit
  import irq_entry_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int ACK_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [VEC_W-1:0] ack_data,
  output logic             strobe,
  output logic             lock,
  output logic [VEC_W-1:0] vec,
  output logic             fin
);
  localparam int CNT_W = (ACK_LEN < 2) ? 1 : $clog2(ACK_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ACK_LEN - 1);

  ack_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= A_IDLE;
      cnt_q  <= '0;
      strobe <= 1'b0;
      lock   <= 1'b0;
      vec    <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st_q)
        A_IDLE: begin
          if (start) begin
            strobe <= 1'b1;
            lock   <= 1'b1;
            cnt_q  <= '0;
            st_q   <= A_ONE;
          end
        end
        A_ONE: begin
          if (cnt_q == LAST) begin
            strobe <= 1'b0;
            cnt_q  <= '0;
            st_q   <= A_GAP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        A_GAP: begin
          strobe <= 1'b1;
          st_q   <= A_TWO;
        end
        default: begin
          if (cnt_q == LAST) begin
            strobe <= 1'b0;
            lock   <= 1'b0;
            vec    <= ack_data;
            fin    <= 1'b1;
            cnt_q  <= '0;
            st_q   <= A_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  p_lock_covers_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    strobe |-> lock);

  p_fin_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin);
endmodule

// File: rtl/irq_push_unit.sv
module irq_push_unit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_sp,
  input  logic              start,
  input  logic [DATA_W-1:0] din,
  input  logic              ready,
  output logic              wr_en,
  output logic [DATA_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] sp_cur,
  output logic              fin
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en  <= 1'b0;
      addr   <= '0;
      wdata  <= '0;
      sp_cur <= '0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (load) begin
        sp_cur <= load_sp;
      end else if (start && !wr_en) begin
        wr_en  <= 1'b1;
        addr   <= sp_cur - STEP;
        wdata  <= din;
        sp_cur <= sp_cur - STEP;
      end else if (wr_en && ready) begin
        wr_en <= 1'b0;
        fin   <= 1'b1;
      end
    end
  end

  p_write_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ready) |=> (wr_en && $stable(addr) && $stable(wdata)));

  p_addr_is_sp_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (addr == sp_cur));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int VEC_W   = 8,
  parameter int ACK_LEN = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_req,
  input  logic [DATA_W-1:0] flags_in,
  input  logic [DATA_W-1:0] cs_in,
  input  logic [DATA_W-1:0] ip_in,
  input  logic [DATA_W-1:0] sp_in,
  output logic              ack_strobe,
  output logic              bus_lock,
  input  logic [VEC_W-1:0]  ack_data,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready,
  output logic              flags_wr_en,
  output logic [DATA_W-1:0] flags_wr_data,
  output logic              done,
  output logic [VEC_W-1:0]  done_vector,
  output logic [DATA_W-1:0] done_sp
);
  localparam logic [DATA_W-1:0] CLR_MASK =
    ~((DATA_W'(1) << TF_POS) | (DATA_W'(1) << IF_POS));

  seq_state_e        st_q;
  logic [DATA_W-1:0] fl_q, cs_q, ip_q;
  logic              accept;
  logic              ack_fin;
  logic [VEC_W-1:0]  ack_vec;
  logic              push_start;
  logic [DATA_W-1:0] push_din;
  logic              push_fin;
  logic [DATA_W-1:0] sp_cur;

  assign accept = (st_q == S_IDLE) && irq_req && flags_in[IF_POS];

  always_comb begin
    push_start = 1'b0;
    push_din   = fl_q;
    case (st_q)
      S_ACK:     begin push_start = ack_fin;  push_din = fl_q; end
      S_CLR_FL:  begin push_start = 1'b1;     push_din = cs_q; end
      S_PUSH_CS: begin push_start = push_fin; push_din = ip_q; end
      default:   begin push_start = 1'b0;     push_din = fl_q; end
    endcase
  end

  irq_ack_unit #(.VEC_W(VEC_W), .ACK_LEN(ACK_LEN)) u_ack (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .ack_data (ack_data),
    .strobe   (ack_strobe),
    .lock     (bus_lock),
    .vec      (ack_vec),
    .fin      (ack_fin)
  );

  irq_push_unit #(.DATA_W(DATA_W)) u_push (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .load_sp (sp_in),
    .start   (push_start),
    .din     (push_din),
    .ready   (mem_ready),
    .wr_en   (mem_wr_en),
    .addr    (mem_addr),
    .wdata   (mem_wdata),
    .sp_cur  (sp_cur),
    .fin     (push_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q          <= S_IDLE;
      fl_q          <= '0;
      cs_q          <= '0;
      ip_q          <= '0;
      flags_wr_en   <= 1'b0;
      flags_wr_data <= '0;
      done          <= 1'b0;
      done_vector   <= '0;
      done_sp       <= '0;
    end else begin
      flags_wr_en <= 1'b0;
      done        <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (accept) begin
            fl_q <= flags_in;
            cs_q <= cs_in;
            ip_q <= ip_in;
            st_q <= S_ACK;
          end
        end
        S_ACK:     if (ack_fin) st_q <= S_PUSH_FL;
        S_PUSH_FL: begin
          if (push_fin) begin
            flags_wr_en   <= 1'b1;
            flags_wr_data <= fl_q & CLR_MASK;
            st_q          <= S_CLR_FL;
          end
        end
        S_CLR_FL:  st_q <= S_PUSH_CS;
        S_PUSH_CS: if (push_fin) st_q <= S_PUSH_IP;
        S_PUSH_IP: begin
          if (push_fin) begin
            done        <= 1'b1;
            done_vector <= ack_vec;
            done_sp     <= sp_cur;
            st_q        <= S_FIN;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_masked_no_ack_r2: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_IDLE && !flags_in[IF_POS]) |=> !ack_strobe);

  p_no_strobe_during_write_r6: assert property (@(posedge clk) disable iff (rst)
    !(ack_strobe && mem_wr_en));

  p_flags_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    flags_wr_en |-> (!flags_wr_data[TF_POS] && !flags_wr_data[IF_POS]));

  p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;
  localparam int W = 16;
  localparam int VW = 8;
  localparam int LEN = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_req = 1'b0;
  logic [W-1:0] flags_reg = '0, cs_v = '0, ip_v = '0, sp_v = '0;
  logic ack_strobe, bus_lock, mem_wr_en, mem_ready, flags_wr_en, done;
  logic [VW-1:0] ack_data, done_vector;
  logic [W-1:0] mem_addr, mem_wdata, flags_wr_data, done_sp;

  int total = 0, bad = 0;
  int ready_gap = 0;
  int ready_cnt = 0;
  logic [VW-1:0] cur_vec = 8'h00, junk_vec = 8'hEE;

  int rises, widths[4], cur_w, gaps, lock_cyc, lock_bad, nwr, nflw, flags_at;
  int ndone, done_long, hold_bad;
  logic [W-1:0] wa[4], wd[4], flw_val, dsp;
  logic [VW-1:0] dvec;
  logic prev_s, prev_d, prev_pend;
  logic [W-1:0] prev_a, prev_wd;

  always #4 clk = ~clk;

  irq_entry_seq #(.DATA_W(W), .VEC_W(VW), .ACK_LEN(LEN)) uut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .flags_in(flags_reg),
    .cs_in(cs_v), .ip_in(ip_v), .sp_in(sp_v),
    .ack_strobe(ack_strobe), .bus_lock(bus_lock), .ack_data(ack_data),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .flags_wr_en(flags_wr_en),
    .flags_wr_data(flags_wr_data), .done(done), .done_vector(done_vector),
    .done_sp(done_sp)
  );

  assign ack_data = (rises == 2 && ack_strobe) ? cur_vec : junk_vec;
  assign mem_ready = (ready_cnt >= ready_gap);

  always @(posedge clk) begin
    #1;
    if (mem_wr_en && !mem_ready) ready_cnt++;
    else ready_cnt = 0;
  end

  task automatic clear_log();
    rises = 0; cur_w = 0; gaps = 0; lock_cyc = 0; lock_bad = 0; nwr = 0;
    nflw = 0; flags_at = -1; ndone = 0; done_long = 0; hold_bad = 0;
    prev_s = 0; prev_d = 0; prev_pend = 0;
    for (int i = 0; i < 4; i++) begin widths[i] = 0; wa[i] = '0; wd[i] = '0; end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ack_strobe && !prev_s) rises++;
      if (ack_strobe) cur_w++;
      if (!ack_strobe && prev_s) begin
        if (rises <= 4 && rises > 0) widths[rises-1] = cur_w;
        cur_w = 0;
      end
      if (bus_lock) lock_cyc++;
      if (bus_lock && !ack_strobe) gaps++;
      if (ack_strobe && !bus_lock) lock_bad++;
      if (prev_pend && (!mem_wr_en || mem_addr != prev_a || mem_wdata != prev_wd))
        hold_bad++;
      prev_pend = mem_wr_en && !mem_ready;
      prev_a = mem_addr; prev_wd = mem_wdata;
      if (mem_wr_en && mem_ready) begin
        if (nwr < 4) begin wa[nwr] = mem_addr; wd[nwr] = mem_wdata; end
        nwr++;
      end
      if (flags_wr_en) begin
        nflw++; flags_at = nwr; flw_val = flags_wr_data; flags_reg = flags_wr_data;
      end
      if (done) begin ndone++; dvec = done_vector; dsp = done_sp; end
      if (done && prev_d) done_long++;
      prev_s = ack_strobe; prev_d = done;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_entry(input logic [W-1:0] f, input logic [W-1:0] cs,
                           input logic [W-1:0] ip, input logic [W-1:0] sp,
                           input logic [VW-1:0] v, input int rgap);
    logic [W-1:0] e1, e2, e3;
    clear_log();
    flags_reg = f; cs_v = cs; ip_v = ip; sp_v = sp; cur_vec = v; ready_gap = rgap;
    @(posedge clk); #1 irq_req = 1'b1;
    for (int i = 0; i < 400 && ndone == 0; i++) @(negedge clk);
    irq_req = 1'b0;
    repeat (6) @(negedge clk);
    e1 = sp - 16'd2; e2 = sp - 16'd4; e3 = sp - 16'd6;
    chk(rises == 2, "R3 strobe count", rises, 2);
    chk(widths[0] == LEN && widths[1] == LEN, "R3 strobe width",
        {widths[0][15:0], widths[1][15:0]}, {16'(LEN), 16'(LEN)});
    chk(gaps == 1, "R4 lock gap clocks", gaps, 1);
    chk(lock_cyc == 2*LEN+1 && lock_bad == 0, "R4 lock length", lock_cyc, 2*LEN+1);
    chk(ndone == 1 && dvec == v, "R5 vector from second cycle", dvec, v);
    chk(nwr == 3, "R8 write count", nwr, 3);
    chk(wa[0] == e1 && wd[0] == f, "R6 flags push", {wa[0], wd[0]}, {e1, f});
    chk(nflw == 1 && flags_at == 1, "R7 flag update position", flags_at, 1);
    chk(flw_val == (f & 16'hFCFF), "R7 flag update value", flw_val, f & 16'hFCFF);
    chk(wa[1] == e2 && wd[1] == cs, "R8 CS push", {wa[1], wd[1]}, {e2, cs});
    chk(wa[2] == e3 && wd[2] == ip, "R8 IP push", {wa[2], wd[2]}, {e3, ip});
    chk(hold_bad == 0, "R9 write held until ready", hold_bad, 0);
    chk(done_long == 0 && dsp == e3, "R10 done pulse and SP", dsp, e3);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    chk(!ack_strobe && !bus_lock && !mem_wr_en && !flags_wr_en && !done,
        "R1 reset outputs", {ack_strobe, bus_lock, mem_wr_en, flags_wr_en, done}, 0);
    @(posedge clk); #1 rst = 1'b0;
  endtask

  task automatic t_masked();
    clear_log();
    flags_reg = 16'h0100; sp_v = 16'h2000;
    @(posedge clk); #1 irq_req = 1'b1;
    repeat (20) @(negedge clk);
    chk(rises == 0 && nwr == 0 && nflw == 0 && ndone == 0, "R2 masked request ignored",
        rises + nwr + nflw + ndone, 0);
    irq_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_basic();      run_entry(16'h0246, 16'hF000, 16'h1234, 16'h8000, 8'h21, 0); endtask
  task automatic t_slow_ready(); run_entry(16'h0FD5, 16'h00A0, 16'hBEEF, 16'h0400, 8'h7C, 3); endtask
  task automatic t_wrap();       run_entry(16'h0200, 16'h5555, 16'hAAAA, 16'h0002, 8'hC3, 1); endtask

  task automatic t_reaccept();
    clear_log();
    @(posedge clk); #1 irq_req = 1'b1;
    repeat (10) @(negedge clk);
    chk(rises == 0, "R10 no restart after entry clears IE", rises, 0);
    irq_req = 1'b0;
    run_entry(16'h0300, 16'h1111, 16'h2222, 16'h3000, 8'h05, 2);
  endtask

  initial begin
    clear_log();
    t_reset();
    t_masked();
    t_basic();
    t_slow_ready();
    t_wrap();
    t_reaccept();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule